// File: doc/BRIEF.md
# Fracturable Dual-Output Lookup Table

A configurable combinational logic cell with eight data inputs and two outputs. A 64-bit truth-table mask and a 3-bit mode code program it. The cell can act as one wide function, or it can split the same mask into two narrower functions. In each split mode the two functions share a fixed set of inputs. An extended mode uses the two mask halves as 5-input functions over four common inputs and picks one of them with a further input.

The mask and the mode sit in a shadow register. That register loads on a clock edge while the write strobe is high and keeps its value otherwise. The outputs are purely combinational from the data inputs and the shadow. Within each sub-function, the lowest-numbered data input drives the least significant bit of the mask index. The second function of each split mode always indexes the upper half of the mask (base 32).

Top module: `flut_cell`

## Requirements
- R1: An active-low asynchronous reset clears the shadow mask and mode to zero. On a rising clock edge with `cfg_we_i` high, the shadow takes `cfg_mask_i` and `cfg_mode_i`. With `cfg_we_i` low, changes on those ports have no effect on the outputs.
- R2: Mode 0 gives a single 6-input function: `out_a_o = mask[d5 d4 d3 d2 d1 d0]`. Inputs d7 and d6 have no effect, and `out_b_o` is 0.
- R3: Mode 1 gives two 5-input functions that share d1 and d0: `out_a_o = mask[{d4,d3,d2,d1,d0}]` and `out_b_o = mask[32 + {d7,d6,d5,d1,d0}]`.
- R4: Mode 2 gives a 5-input and a 4-input function that share d0: `out_a_o = mask[{d4..d0}]` and `out_b_o = mask[32 + {d7,d6,d5,d0}]`.
- R5: Mode 3 gives a 5-input and a 3-input function with no shared input: `out_a_o = mask[{d4..d0}]` and `out_b_o = mask[32 + {d7,d6,d5}]`.
- R6: Mode 4 gives two 4-input functions with no shared input: `out_a_o = mask[{d3..d0}]` and `out_b_o = mask[32 + {d7..d4}]`.
- R7: Mode 5 is the extended mode. With d6 = 0, `out_a_o = mask[{d4,d3..d0}]`. With d6 = 1, `out_a_o = mask[32 + {d5,d3..d0}]`. Input d7 has no effect, and `out_b_o` is 0.
- R8: Mode codes 6 and 7 are reserved, and both outputs are 0 whatever the mask and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration shadow |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Loads mask and mode on the next rising edge |
| cfg_mask_i | input | 64 | Truth-table mask to load |
| cfg_mode_i | input | 3 | Mode code to load |
| data_i | input | 8 | Data inputs d7..d0 |
| out_a_o | output | 1 | First function output |
| out_b_o | output | 1 | Second function output |

## Verification
Walking one-hot masks in mode 0 prove that each input lands on its own index bit, so a swapped or misordered input shows up at once. Toggling d7 and d6 in mode 0, and d7 in mode 5, shows that the unused inputs are ignored. Dense random masks with random data cover every mode code. This exposes a wrong shared input or a wrong mask base for the second function. An all-ones mask makes any leak through the reserved codes visible. Holding the write strobe low while changing the configuration ports separates a held shadow from a transparent one.

// File: rtl/flut_pkg.sv
package flut_pkg;
  localparam int unsigned N_IN   = 8;
  localparam int unsigned MASK_W = 64;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned ADDR_W = $clog2(MASK_W);
  localparam int unsigned N_OUT  = 2;

  localparam logic [MODE_W-1:0] MODE_L6   = 3'd0;
  localparam logic [MODE_W-1:0] MODE_L5X2 = 3'd1;
  localparam logic [MODE_W-1:0] MODE_L5L4 = 3'd2;
  localparam logic [MODE_W-1:0] MODE_L5L3 = 3'd3;
  localparam logic [MODE_W-1:0] MODE_L4X2 = 3'd4;
  localparam logic [MODE_W-1:0] MODE_L7   = 3'd5;
endpackage

// File: rtl/flut_cfg_reg.sv
module flut_cfg_reg
  import flut_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [MODE_W-1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      mode_o <= '0;
    end else if (we_i) begin
      mask_o <= mask_i;
      mode_o <= mode_i;
    end
  end
endmodule

// File: rtl/flut_route.sv
module flut_route
  import flut_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [N_IN-1:0]   d_i,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [ADDR_W-1:0] addr_b_o,
  output logic              en_a_o,
  output logic              en_b_o,
  output logic              a_from_b_o
);
  // second sub-function always indexes the upper mask half
  always_comb begin
    addr_a_o   = '0;
    addr_b_o   = '0;
    en_a_o     = 1'b0;
    en_b_o     = 1'b0;
    a_from_b_o = 1'b0;
    unique case (mode_i)
      MODE_L6: begin
        addr_a_o = d_i[5:0];
        en_a_o   = 1'b1;
      end
      MODE_L5X2: begin
        addr_a_o = {1'b0, d_i[4:0]};
        addr_b_o = {1'b1, d_i[7:5], d_i[1:0]};
        en_a_o   = 1'b1;
        en_b_o   = 1'b1;
      end
      MODE_L5L4: begin
        addr_a_o = {1'b0, d_i[4:0]};
        addr_b_o = {2'b10, d_i[7:5], d_i[0]};
        en_a_o   = 1'b1;
        en_b_o   = 1'b1;
      end
      MODE_L5L3: begin
        addr_a_o = {1'b0, d_i[4:0]};
        addr_b_o = {3'b100, d_i[7:5]};
        en_a_o   = 1'b1;
        en_b_o   = 1'b1;
      end
      MODE_L4X2: begin
        addr_a_o = {2'b00, d_i[3:0]};
        addr_b_o = {2'b10, d_i[7:4]};
        en_a_o   = 1'b1;
        en_b_o   = 1'b1;
      end
      MODE_L7: begin
        addr_a_o   = {1'b0, d_i[4:0]};
        addr_b_o   = {1'b1, d_i[5], d_i[3:0]};
        en_a_o     = 1'b1;
        a_from_b_o = d_i[6];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flut_lookup.sv
module flut_lookup
  import flut_pkg::*;
(
  input  logic [MASK_W-1:0] mask_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bit_o
);
  assign bit_o = mask_i[addr_i];
endmodule

// File: rtl/flut_cell.sv
module flut_cell
  import flut_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [MASK_W-1:0] cfg_mask_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [N_IN-1:0]   data_i,
  output logic              out_a_o,
  output logic              out_b_o
);
  logic [MASK_W-1:0] mask_q;
  logic [MODE_W-1:0] mode_q;
  logic [ADDR_W-1:0] addr [N_OUT];
  logic [N_OUT-1:0]  lut_bit;
  logic              en_a, en_b, a_from_b;

  flut_cfg_reg i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .mask_i (cfg_mask_i),
    .mode_i (cfg_mode_i),
    .mask_o (mask_q),
    .mode_o (mode_q)
  );

  flut_route i_route (
    .mode_i     (mode_q),
    .d_i        (data_i),
    .addr_a_o   (addr[0]),
    .addr_b_o   (addr[1]),
    .en_a_o     (en_a),
    .en_b_o     (en_b),
    .a_from_b_o (a_from_b)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_lut
    flut_lookup i_lookup (
      .mask_i (mask_q),
      .addr_i (addr[g]),
      .bit_o  (lut_bit[g])
    );
  end

  assign out_a_o = en_a & (a_from_b ? lut_bit[1] : lut_bit[0]);
  assign out_b_o = en_b & lut_bit[1];
endmodule

// File: rtl/flut_cell_chk.sv
module flut_cell_chk
  import flut_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [MASK_W-1:0] cfg_mask_i,
  input logic [MODE_W-1:0] cfg_mode_i,
  input logic [N_IN-1:0]   data_i,
  input logic [MASK_W-1:0] mask_q,
  input logic [MODE_W-1:0] mode_q,
  input logic              out_a_o,
  input logic              out_b_o
);
  a_r1_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(mask_q) && $stable(mode_q));

  a_r1_cfg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (mask_q == $past(cfg_mask_i)) && (mode_q == $past(cfg_mode_i)));

  a_r2_single_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_L6) |-> (out_a_o == mask_q[data_i[5:0]]));

  a_r2_single_b_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_L6) |-> !out_b_o);

  a_r6_quad_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_L4X2) |-> (out_b_o == mask_q[{2'b10, data_i[7:4]}]));

  a_r7_ext_b_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_L7) |-> !out_b_o);

  a_r8_reserved_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q > MODE_L7) |-> !out_a_o && !out_b_o);
endmodule

bind flut_cell flut_cell_chk i_chk (.*);

// File: tb/test_flut_cell.sv
module test_flut_cell;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [63:0] cfg_mask_i = '0;
  logic [2:0]  cfg_mode_i = '0;
  logic [7:0]  data_i = '0;
  logic        out_a_o, out_b_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  flut_cell i_flut_cell (.*);

  function automatic logic ref_a(input logic [63:0] m, input logic [2:0] md, input logic [7:0] d);
    case (md)
      3'd0: return m[d[5:0]];
      3'd1, 3'd2, 3'd3: return m[{1'b0, d[4:0]}];
      3'd4: return m[{2'b00, d[3:0]}];
      3'd5: return d[6] ? m[32 + int'({d[5], d[3:0]})] : m[{1'b0, d[4:0]}];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ref_b(input logic [63:0] m, input logic [2:0] md, input logic [7:0] d);
    case (md)
      3'd1: return m[32 + int'({d[7], d[6], d[5], d[1], d[0]})];
      3'd2: return m[32 + int'({d[7], d[6], d[5], d[0]})];
      3'd3: return m[32 + int'({d[7], d[6], d[5]})];
      3'd4: return m[32 + int'(d[7:4])];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] md);
    case (md)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (data=%h)", tag, act, exp, data_i);
    end
  endtask

  task automatic load_cfg(input logic [63:0] m, input logic [2:0] md);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_mask_i = m; cfg_mode_i = md;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic apply(input logic [7:0] d, input logic [63:0] m, input logic [2:0] md, input string tag);
    data_i = d;
    #2;
    chk({tag, " out_a"}, out_a_o, ref_a(m, md, d));
    chk({tag, " out_b"}, out_b_o, ref_b(m, md, d));
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] m;
    logic [2:0]  md;
    logic        ref_o;
    void'($urandom(32'd7113));
    #25 rst_ni = 1'b1;

    // R1: reset leaves zero mask, mode 0
    @(negedge clk_i);
    data_i = 8'hFF; #2;
    chk("R1 reset out_a", out_a_o, 1'b0);
    chk("R1 reset out_b", out_b_o, 1'b0);

    // R1: writes without strobe are ignored
    cfg_mask_i = '1; cfg_mode_i = 3'd1;
    @(negedge clk_i); @(negedge clk_i);
    data_i = 8'h00; #2;
    chk("R1 no-strobe out_a", out_a_o, 1'b0);
    chk("R1 no-strobe out_b", out_b_o, 1'b0);

    // R2: walking one-hot, index bit order, d7/d6 ignored
    for (int k = 0; k < 64; k += 5) begin
      m = 64'd1 << k;
      load_cfg(m, 3'd0);
      for (int hi = 0; hi < 4; hi++) begin
        data_i = {hi[1:0], k[5:0]}; #2;
        chk("R2 one-hot hit", out_a_o, 1'b1);
        chk("R2 out_b low", out_b_o, 1'b0);
      end
      data_i = {2'b00, k[5:0] ^ 6'b000001}; #2;
      chk("R2 one-hot miss", out_a_o, 1'b0);
    end

    // R7: d7 has no effect in extended mode
    m = {$urandom(), $urandom()};
    load_cfg(m, 3'd5);
    for (int j = 0; j < 64; j++) begin
      md = 3'd5;
      data_i = {1'b0, 1'(j), 6'($urandom())}; #2;
      ref_o = out_a_o;
      data_i[7] = 1'b1; #2;
      chk("R7 d7 ignored", out_a_o, ref_o);
      apply(data_i, m, md, "R7");
    end

    // R8: reserved codes with all-ones mask
    load_cfg('1, 3'd6);
    apply(8'hA5, '1, 3'd6, "R8");
    apply(8'h5A, '1, 3'd6, "R8");
    load_cfg('1, 3'd7);
    apply(8'hFF, '1, 3'd7, "R8");
    apply(8'h00, '1, 3'd7, "R8");

    // random sweep over all modes (R2..R8), with held-config check (R1)
    for (int it = 0; it < 400; it++) begin
      m  = {$urandom(), $urandom()};
      md = 3'($urandom());
      load_cfg(m, md);
      cfg_mask_i = ~m; cfg_mode_i = md + 3'd1;
      for (int j = 0; j < 8; j++) begin
        apply(8'($urandom()), m, md, tag_of(md));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule